// File: doc/BRIEF.md
# Front-End Readout Data Generator

This block stands in for a string of front-end readout chips so that downstream pipeline processors can be exercised with no detector electronics attached. A configuration source supplies a chip count, a words-per-chip count and five behaviour flags. A load strobe captures the counts and arms a readout. From then on, every back-end clock strobe from the host releases exactly one data word. The word is written into twelve identical output lanes, one for each consumer.

Each emulated chip starts with a header word and then delivers its body words. Body words are either a fixed pattern or a running 8-bit count. A separate command recorder keeps the most recent code written on the port-card-A command bus. Its low bits are attached to every generated word as a status field. Software can read that field back to confirm which command was issued before readout. A done flag marks the end of the readout. The generator then stays idle until the next load strobe.

Top module: `fe_readout_emu`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid`, `done`, every `out_data` lane and every `out_stat` lane are zero.
- R2: A `bclk_stb` accepted during an armed readout produces exactly one word: `out_valid` is high for one cycle, on the cycle after the strobe edge. `out_valid` is never high unless `bclk_stb` was high on the previous edge. A strobe while the generator is idle produces nothing.
- R3: All twelve 8-bit lanes of `out_data` (lane k at bits 8k+7..8k) carry the same value at all times. All twelve 4-bit lanes of `out_stat` (lane k at bits 4k+3..4k) also carry the same value at all times.
- R4: `cfg_chips_load` captures `cfg_chips` (N) and `cfg_words` (W). The readout that follows is N chips in index order 0..N-1. Each chip is one header word followed by W body words.
- R5: With `cfg_id_sel`=1, a header word is the chip index in bits 3..0 with bits 7..4 zero. With `cfg_id_sel`=0, a header word is 0x00.
- R6: With `cfg_var_data`=1, a body word is an 8-bit counter. The counter is cleared by the load strobe, advances by one after each such word (wrapping modulo 256), and runs on across chips. With `cfg_var_data`=0, a body word is 0x55 when `cfg_data_type`=0 and 0xAA when `cfg_data_type`=1.
- R7: When W=0, `cfg_null_sel` (sampled at the load strobe) picks the behaviour. With `cfg_null_sel`=1, each chip gives only its header word. With `cfg_null_sel`=0, no word is produced. A readout with no words (N=0, or W=0 with `cfg_null_sel`=0) raises `done` on the cycle after the load strobe.
- R8: While `cfg_inhibit`=1, strobes are ignored. `out_valid` stays low, `out_data` holds its value and the readout position does not move.
- R9: `done` rises on the same cycle that the last word appears on `out_valid`. It stays high until the next load strobe. While it is high and no load arrives, no word is produced.
- R10: Each `cmd_a_valid` cycle stores `cmd_a_code` and has no other effect. Each word's `out_stat` equals bits 3..0 of the code stored before the strobe edge that released the word.
- R11: A load strobe during a readout abandons it and starts the new readout from chip 0, with the counter cleared. A load wins over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_stb | input | 1 | Back-end clock strobe, one word per accepted strobe |
| cmd_a_valid | input | 1 | Port-card-A command write |
| cmd_a_code | input | 8 | Port-card-A command code |
| cfg_chips | input | 4 | Number of emulated chips |
| cfg_chips_load | input | 1 | Captures the counts and arms a readout |
| cfg_words | input | 7 | Body words per chip |
| cfg_var_data | input | 1 | 1: counting body words, 0: fixed pattern |
| cfg_data_type | input | 1 | Fixed pattern select: 0 gives 0x55, 1 gives 0xAA |
| cfg_id_sel | input | 1 | 1: header carries the chip index |
| cfg_null_sel | input | 1 | 1: chips with zero words still give a header |
| cfg_inhibit | input | 1 | 1: strobes are ignored |
| out_data | output | 96 | Twelve identical 8-bit data lanes |
| out_stat | output | 48 | Twelve identical 4-bit status lanes |
| out_valid | output | 1 | A new word is on the lanes |
| done | output | 1 | Readout finished |

## Verification
The bench targets four corner cases.
- Counter wrap across chip boundaries: three chips of 127 counting words. A counter that restarts per chip, or that is wider than 8 bits, gives the wrong body words after the first chip or after word 255.
- Zero words per chip: run with and without the null option. A generator that ignores the option either emits stray headers or hangs without raising `done`.
- Inhibit mid-readout and status replay: inhibit is applied partway through, and the command code is changed between strobes. A design that lets an inhibited strobe through, or samples the status late, gives a word out of order or a status from the wrong command.
- Load during a readout: a load arrives before the readout ends. A design that does not clear the position resumes the old readout instead of restarting at chip 0.

// File: rtl/fe_emu_pkg.sv
package fe_emu_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HDR  = 2'd1,
    SQ_BODY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fe_emu_cmd_rec.sv
module fe_emu_cmd_rec #(
  parameter int CMD_W  = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_code,
  output logic [STAT_W-1:0] stat
);
  logic [CMD_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)        code_q <= '0;
    else if (wr_en) code_q <= wr_code;
  end

  assign stat = code_q[STAT_W-1:0];
endmodule

// File: rtl/fe_emu_seq.sv
module fe_emu_seq
  import fe_emu_pkg::*;
#(
  parameter int         CHIP_W   = 4,
  parameter int         WORD_W   = 7,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] FIX_PAT0 = 8'h55,
  parameter logic [7:0] FIX_PAT1 = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              load,
  input  logic [CHIP_W-1:0] chips,
  input  logic [WORD_W-1:0] words,
  input  logic              var_data,
  input  logic              data_type,
  input  logic              id_sel,
  input  logic              null_sel,
  input  logic              inhibit,
  output logic              fire,
  output logic [DATA_W-1:0] word,
  output logic              done
);
  seq_state_e        state_q;
  logic [CHIP_W-1:0] nchips_q, chip_q;
  logic [WORD_W-1:0] nwords_q, wcnt_q;
  logic [DATA_W-1:0] cnt_q;
  logic              last_chip, last_word, empty;

  assign fire      = stb && !inhibit && !load && (state_q != SQ_IDLE);
  assign last_chip = (chip_q + 1'b1) == nchips_q;
  assign last_word = (wcnt_q + 1'b1) == nwords_q;
  assign empty     = (chips == '0) || ((words == '0) && !null_sel);

  always_comb begin
    if (state_q == SQ_HDR)
      word = id_sel ? DATA_W'(chip_q) : '0;
    else if (var_data)
      word = cnt_q;
    else
      word = data_type ? DATA_W'(FIX_PAT1) : DATA_W'(FIX_PAT0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      nchips_q <= '0;
      nwords_q <= '0;
      chip_q   <= '0;
      wcnt_q   <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
    end else if (load) begin
      nchips_q <= chips;
      nwords_q <= words;
      chip_q   <= '0;
      wcnt_q   <= '0;
      cnt_q    <= '0;
      state_q  <= empty ? SQ_IDLE : SQ_HDR;
      done     <= empty;
    end else if (fire) begin
      case (state_q)
        SQ_HDR: begin
          wcnt_q <= '0;
          if (nwords_q != '0) begin
            state_q <= SQ_BODY;
          end else if (last_chip) begin
            state_q <= SQ_IDLE;
            done    <= 1'b1;
          end else begin
            chip_q <= chip_q + 1'b1;
          end
        end
        SQ_BODY: begin
          if (var_data) cnt_q <= cnt_q + 1'b1;
          if (!last_word) begin
            wcnt_q <= wcnt_q + 1'b1;
          end else if (last_chip) begin
            state_q <= SQ_IDLE;
            done    <= 1'b1;
          end else begin
            chip_q  <= chip_q + 1'b1;
            state_q <= SQ_HDR;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fe_emu_lane.sv
module fe_emu_lane #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] d_data,
  input  logic [STAT_W-1:0] d_stat,
  output logic [DATA_W-1:0] q_data,
  output logic [STAT_W-1:0] q_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_data <= '0;
      q_stat <= '0;
    end else if (ld) begin
      q_data <= d_data;
      q_stat <= d_stat;
    end
  end
endmodule

// File: rtl/fe_readout_emu.sv
module fe_readout_emu #(
  parameter int NOUT   = 12,
  parameter int CHIP_W = 4,
  parameter int WORD_W = 7,
  parameter int DATA_W = 8,
  parameter int CMD_W  = 8,
  parameter int STAT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bclk_stb,
  input  logic                     cmd_a_valid,
  input  logic [CMD_W-1:0]         cmd_a_code,
  input  logic [CHIP_W-1:0]        cfg_chips,
  input  logic                     cfg_chips_load,
  input  logic [WORD_W-1:0]        cfg_words,
  input  logic                     cfg_var_data,
  input  logic                     cfg_data_type,
  input  logic                     cfg_id_sel,
  input  logic                     cfg_null_sel,
  input  logic                     cfg_inhibit,
  output logic [NOUT*DATA_W-1:0]   out_data,
  output logic [NOUT*STAT_W-1:0]   out_stat,
  output logic                     out_valid,
  output logic                     done
);
  logic              fire;
  logic [DATA_W-1:0] gen_word;
  logic [STAT_W-1:0] rec_stat;

  fe_emu_cmd_rec #(.CMD_W(CMD_W), .STAT_W(STAT_W)) u_rec (
    .clk(clk), .rst(rst), .wr_en(cmd_a_valid), .wr_code(cmd_a_code),
    .stat(rec_stat)
  );

  fe_emu_seq #(.CHIP_W(CHIP_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .stb(bclk_stb), .load(cfg_chips_load),
    .chips(cfg_chips), .words(cfg_words), .var_data(cfg_var_data),
    .data_type(cfg_data_type), .id_sel(cfg_id_sel), .null_sel(cfg_null_sel),
    .inhibit(cfg_inhibit), .fire(fire), .word(gen_word), .done(done)
  );

  for (genvar k = 0; k < NOUT; k++) begin : g_lane
    fe_emu_lane #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_lane (
      .clk(clk), .rst(rst), .ld(fire), .d_data(gen_word), .d_stat(rec_stat),
      .q_data(out_data[k*DATA_W +: DATA_W]),
      .q_stat(out_stat[k*STAT_W +: STAT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= fire;
  end
endmodule

// File: rtl/fe_readout_emu_chk.sv
module fe_readout_emu_chk #(
  parameter int NOUT   = 12,
  parameter int DATA_W = 8,
  parameter int STAT_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bclk_stb,
  input logic                   cfg_chips_load,
  input logic                   cfg_inhibit,
  input logic [NOUT*DATA_W-1:0] out_data,
  input logic [NOUT*STAT_W-1:0] out_stat,
  input logic                   out_valid,
  input logic                   done,
  input logic [STAT_W-1:0]      rec_stat
);
  a_r3_lanes_match: assert property (@(posedge clk) disable iff (rst)
    (out_data == {NOUT{out_data[DATA_W-1:0]}}) &&
    (out_stat == {NOUT{out_stat[STAT_W-1:0]}}));

  a_r2_valid_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(bclk_stb));

  a_r8_inhibit_holds: assert property (@(posedge clk) disable iff (rst)
    cfg_inhibit |=> (!out_valid && $stable(out_data)));

  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    (done && !cfg_chips_load) |=> !out_valid);

  a_r9_done_with_last: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && !$past(cfg_chips_load)) |-> out_valid);

  a_r10_status_replay: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_stat[STAT_W-1:0] == $past(rec_stat)));
endmodule

bind fe_readout_emu fe_readout_emu_chk #(.NOUT(NOUT), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .bclk_stb(bclk_stb), .cfg_chips_load(cfg_chips_load),
  .cfg_inhibit(cfg_inhibit), .out_data(out_data), .out_stat(out_stat),
  .out_valid(out_valid), .done(done), .rec_stat(rec_stat)
);

// File: tb/fe_readout_emu_bench.sv
module fe_readout_emu_bench;
  localparam int NOUT = 12;
  localparam int DW   = 8;
  localparam int SW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk_stb = 0, cmd_a_valid = 0, cfg_chips_load = 0;
  logic [7:0] cmd_a_code = '0;
  logic [3:0] cfg_chips = '0;
  logic [6:0] cfg_words = '0;
  logic cfg_var_data = 0, cfg_data_type = 0, cfg_id_sel = 0, cfg_null_sel = 0, cfg_inhibit = 0;
  logic [NOUT*DW-1:0] out_data;
  logic [NOUT*SW-1:0] out_stat;
  logic out_valid, done;

  int checks = 0;
  int errors = 0;
  logic [3:0] cur_stat = '0;
  string cur_req = "R4";
  logic [7:0]  plan[$];
  logic [11:0] exp_q[$];

  always #2ns clk = ~clk;

  fe_readout_emu u_fe_readout_emu (
    .clk(clk), .rst(rst), .bclk_stb(bclk_stb), .cmd_a_valid(cmd_a_valid),
    .cmd_a_code(cmd_a_code), .cfg_chips(cfg_chips), .cfg_chips_load(cfg_chips_load),
    .cfg_words(cfg_words), .cfg_var_data(cfg_var_data), .cfg_data_type(cfg_data_type),
    .cfg_id_sel(cfg_id_sel), .cfg_null_sel(cfg_null_sel), .cfg_inhibit(cfg_inhibit),
    .out_data(out_data), .out_stat(out_stat), .out_valid(out_valid), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected item per valid word.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected word", int'(out_data[DW-1:0]), 0);
      end else begin
        logic [11:0] e;
        bit ok;
        e = exp_q.pop_front();
        ok = 1'b1;
        for (int k = 0; k < NOUT; k++) begin
          if (out_data[k*DW +: DW] != e[7:0]) ok = 1'b0;
          if (out_stat[k*SW +: SW] != e[11:8]) ok = 1'b0;
        end
        check(ok, {cur_req, "/R3/R10"}, "word {stat,data} on all lanes",
              int'({out_stat[SW-1:0], out_data[DW-1:0]}), int'(e));
      end
    end
  end

  // Expected-word model built from the requirements.
  task automatic build_plan(input int n, input int w, input bit vd, input bit dt,
                            input bit ids, input bit nul);
    logic [7:0] cnt = 8'h00;
    plan.delete();
    if (n == 0 || (w == 0 && !nul)) return;
    for (int c = 0; c < n; c++) begin
      plan.push_back(ids ? 8'(c) : 8'h00);
      for (int j = 0; j < w; j++) begin
        if (vd) begin plan.push_back(cnt); cnt = cnt + 8'd1; end
        else    plan.push_back(dt ? 8'hAA : 8'h55);
      end
    end
  endtask

  task automatic load(input int n, input int w, input bit vd, input bit dt,
                      input bit ids, input bit nul);
    @(negedge clk);
    cfg_chips = 4'(n); cfg_words = 7'(w); cfg_var_data = vd; cfg_data_type = dt;
    cfg_id_sel = ids; cfg_null_sel = nul; cfg_chips_load = 1'b1;
    build_plan(n, w, vd, dt, ids, nul);
    @(negedge clk);
    cfg_chips_load = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    bclk_stb = 1'b1;
    if (!cfg_inhibit && plan.size() > 0) exp_q.push_back({cur_stat, plan.pop_front()});
    @(negedge clk);
    bclk_stb = 1'b0;
  endtask

  task automatic command(input logic [7:0] code);
    @(negedge clk);
    cmd_a_valid = 1'b1; cmd_a_code = code; cur_stat = code[3:0];
    @(negedge clk);
    cmd_a_valid = 1'b0;
  endtask

  task automatic run_all(input int nstb);
    for (int i = 0; i < nstb; i++) strobe();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && done == 0 && out_data == '0 && out_stat == '0, "R1",
          "reset state", int'(out_data[7:0]), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && done == 0 && out_data == '0, "R1", "after reset", int'(done), 0);

    // R2: strobe while idle gives nothing
    strobe();
    check(out_valid == 0, "R2", "idle strobe", int'(out_valid), 0);

    // R4 R5 R10: three chips, two fixed words, chip ids
    command(8'h3C);
    cur_req = "R4/R5";
    load(3, 2, 0, 0, 1, 0);
    check(done == 0, "R9", "done cleared by load", int'(done), 0);
    run_all(8);
    check(done == 0, "R9", "done before last word", int'(done), 0);
    strobe();
    check(done == 1 && out_valid == 1, "R9", "done with last word", int'(done), 1);
    strobe();
    check(out_valid == 0 && done == 1, "R9", "no word after done", int'(out_valid), 0);

    // R6: counting words across chips, zero headers, status changes mid-run
    cur_req = "R6/R5";
    load(2, 3, 1, 1, 0, 0);
    run_all(3);
    command(8'hA7);
    run_all(5);
    check(done == 1, "R9", "done after counting run", int'(done), 1);

    // R6: fixed 0xAA pattern
    cur_req = "R6";
    load(1, 2, 0, 1, 1, 0);
    run_all(3);

    // R7: zero words with header kept
    cur_req = "R7";
    load(3, 0, 0, 0, 1, 1);
    run_all(3);
    check(done == 1, "R7", "done after header-only chips", int'(done), 1);

    // R7: zero words, chips skipped
    load(3, 0, 0, 0, 1, 0);
    check(done == 1, "R7", "done right after empty load", int'(done), 1);
    strobe();
    check(out_valid == 0, "R7", "no word from skipped chips", int'(out_valid), 0);
    load(0, 5, 0, 0, 1, 0);
    check(done == 1, "R7", "done with zero chips", int'(done), 1);

    // R8: inhibit mid-readout
    cur_req = "R8";
    load(2, 2, 0, 0, 1, 0);
    run_all(2);
    cfg_inhibit = 1'b1;
    strobe();
    check(out_valid == 0, "R8", "inhibited strobe valid", int'(out_valid), 0);
    strobe();
    check(out_data[7:0] == 8'h55 && exp_q.size() == 0, "R8", "data held",
          int'(out_data[7:0]), 8'h55);
    @(negedge clk);
    cfg_inhibit = 1'b0;
    run_all(4);
    check(done == 1, "R8", "readout resumes and completes", int'(done), 1);

    // R10: command and strobe together use the old code
    cur_req = "R10";
    load(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    bclk_stb = 1'b1; cmd_a_valid = 1'b1; cmd_a_code = 8'h52;
    exp_q.push_back({cur_stat, plan.pop_front()});
    cur_stat = 4'h2;
    @(negedge clk);
    bclk_stb = 1'b0; cmd_a_valid = 1'b0;
    strobe();

    // R11: reload mid-readout restarts
    cur_req = "R11";
    load(3, 4, 1, 0, 1, 0);
    run_all(4);
    load(2, 1, 1, 0, 1, 0);
    check(done == 0, "R11", "done low after reload", int'(done), 0);
    run_all(4);
    check(done == 1, "R11", "restarted readout ends", int'(done), 1);

    // R6 R4 boundary: maximum words, counter wraps
    cur_req = "R6";
    load(3, 127, 1, 0, 1, 0);
    run_all(384);
    check(done == 1, "R6", "long run done", int'(done), 1);
    cur_req = "R4";
    load(15, 1, 1, 0, 1, 0);
    run_all(30);
    check(done == 1, "R4", "fifteen chips done", int'(done), 1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", "all expected words seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule